// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a compact 32-bit processor that completes one instruction per clock. Each cycle it presents its program counter on an instruction fetch port, decodes the returned word, reads two operands from a 32-entry register file, computes either an arithmetic result or a memory address, and commits the result on the next rising edge. It also computes the next program counter in the same cycle. Instruction and data storage sit outside the block. The fetch port and the data port are both combinational toward the surrounding memories.

The supported operations are add, subtract, shift-left-logical and register-indirect jump in the register format. The immediate format covers add-immediate, load word, store word, branch-on-equal and branch-on-not-equal. The long-jump format covers an unconditional jump. Any opcode or function code outside this set retires as a no-operation: it writes no register, stores nothing and falls through to the next word.

Top module: `sc32_core`

## Requirements
- R1: While reset is high, a rising clock edge loads the program counter with 0x00400000, and `imem_addr` shows this value after that edge.
- R2: An instruction that is not a branch or jump moves the program counter to its own address plus 4.
- R3: With opcode 0 (bits 31:26), funct 32 (bits 5:0) writes rs+rt and funct 34 writes rs−rt into register rd. Fields: rs is bits 25:21, rt is bits 20:16, rd is bits 15:11.
- R4: With opcode 0 and funct 0, the core writes rt shifted left by shamt (bits 10:6) into rd.
- R5: Opcode 8 writes rs plus the sign-extended 16-bit immediate (bits 15:0) into rt.
- R6: Opcodes 35 (load) and 43 (store) use rs plus the sign-extended immediate as the byte address on `dmem_addr`. A store raises `dmem_we` with rt on `dmem_wdata`. A load writes `dmem_rdata` into rt. `dmem_we` is high only for opcode 43.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. A taken branch goes to PC+4 plus the sign-extended immediate shifted left by 2. An untaken branch goes to PC+4.
- R9: Opcode 2 jumps to {PC+4 bits 31:28, bits 25:0 of the instruction, 2'b00}.
- R10: With opcode 0 and funct 8, the core loads the program counter from register rs.
- R11: An undefined opcode, or opcode 0 with an undefined funct, writes no register, does not raise `dmem_we`, and advances the PC by 4.
- R12: The power-of-two loop program ends with 128 and 7 in its two loop registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |

## Verification
A wrong next-PC choice shows at once: `imem_addr` diverges from the reference model on the very next cycle. A corrupted register stays hidden until some instruction reads it. It then shows as a wrong store address, wrong store data or a wrong branch direction. For that reason the test program stores every result it computes, and the bench compares the fetch address and the store strobe, address and data with the model on every clock. An undefined instruction that wrongly writes a register is caught because a later store reads that same register.

// File: rtl/sc32_pkg.sv
package sc32_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLL} alu_op_e;
  typedef enum logic [2:0] {NPC_SEQ, NPC_BEQ, NPC_BNE, NPC_JUMP, NPC_REG} npc_sel_e;

  typedef struct packed {
    logic     reg_we;
    logic     dst_rd;
    logic     use_imm;
    logic     mem_we;
    logic     mem_rd;
    alu_op_e  alu;
    npc_sel_e npc;
  } ctrl_t;
endpackage

// File: rtl/sc32_regfile.sv
module sc32_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int ADDR_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] store [REG_CNT];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) store[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store[raddr_b];
endmodule

// File: rtl/sc32_decode.sv
module sc32_decode
  import sc32_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{reg_we: 1'b0, dst_rd: 1'b0, use_imm: 1'b0, mem_we: 1'b0,
             mem_rd: 1'b0, alu: ALU_ADD, npc: NPC_SEQ};
    case (opcode)
      OP_RTYPE: begin
        case (funct)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu = ALU_SUB; end
          FN_SLL: begin ctrl.reg_we = 1'b1; ctrl.dst_rd = 1'b1; ctrl.alu = ALU_SLL; end
          FN_JR:  ctrl.npc = NPC_REG;
          default: ;
        endcase
      end
      OP_ADDI: begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; end
      OP_LW:   begin ctrl.reg_we = 1'b1; ctrl.use_imm = 1'b1; ctrl.mem_rd = 1'b1; end
      OP_SW:   begin ctrl.use_imm = 1'b1; ctrl.mem_we = 1'b1; end
      OP_BEQ:  ctrl.npc = NPC_BEQ;
      OP_BNE:  ctrl.npc = NPC_BNE;
      OP_J:    ctrl.npc = NPC_JUMP;
      default: ;
    endcase
  end
endmodule

// File: rtl/sc32_alu.sv
module sc32_alu
  import sc32_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   shamt,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (op)
      ALU_SUB: y = a - b;
      ALU_SLL: y = b << shamt;
      default: y = a + b;
    endcase
  end
endmodule

// File: rtl/sc32_core.sv
module sc32_core
  import sc32_pkg::*;
#(
  parameter int          REG_CNT  = 32,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int RA_W = $clog2(REG_CNT);

  logic [XLEN-1:0] pc_q, pc_seq, pc_br, pc_jmp, pc_nxt;
  logic [XLEN-1:0] imm_sx, rs_val, rt_val, alu_b, alu_y, wb_val;
  logic [RA_W-1:0] wr_idx;
  logic            same;
  ctrl_t           ctl;

  sc32_decode u_dec (
    .opcode (imem_data[31:26]),
    .funct  (imem_data[5:0]),
    .ctrl   (ctl)
  );

  sc32_regfile #(.DATA_W(XLEN), .REG_CNT(REG_CNT)) u_rf (
    .clk     (clk),
    .we      (ctl.reg_we && !rst),
    .waddr   (wr_idx),
    .wdata   (wb_val),
    .raddr_a (imem_data[25:21]),
    .raddr_b (imem_data[20:16]),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign imm_sx = {{(XLEN-16){imem_data[15]}}, imem_data[15:0]};
  assign alu_b  = ctl.use_imm ? imm_sx : rt_val;

  sc32_alu #(.DATA_W(XLEN)) u_alu (
    .op    (ctl.alu),
    .a     (rs_val),
    .b     (alu_b),
    .shamt (imem_data[10:6]),
    .y     (alu_y)
  );

  assign wr_idx = ctl.dst_rd ? imem_data[15:11] : imem_data[20:16];
  assign wb_val = ctl.mem_rd ? dmem_rdata : alu_y;

  assign pc_seq = pc_q + 32'd4;
  assign pc_br  = pc_seq + (imm_sx << 2);
  assign pc_jmp = {pc_seq[31:28], imem_data[25:0], 2'b00};
  assign same   = (rs_val == rt_val);

  always_comb begin
    case (ctl.npc)
      NPC_BEQ:  pc_nxt = same ? pc_br : pc_seq;
      NPC_BNE:  pc_nxt = same ? pc_seq : pc_br;
      NPC_JUMP: pc_nxt = pc_jmp;
      NPC_REG:  pc_nxt = rs_val;
      default:  pc_nxt = pc_seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_nxt;
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we && !rst;
endmodule

// File: rtl/sc32_core_chk.sv
module sc32_core_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_addr,
  input logic [31:0] imem_data,
  input logic        dmem_we
);
  logic [5:0]  op;
  logic [31:0] nx_seq, nx_br;
  logic        known;

  assign op     = imem_data[31:26];
  assign nx_seq = imem_addr + 32'd4;
  assign nx_br  = nx_seq + {imem_data[15], imem_data[15], imem_data[15], imem_data[15],
                            imem_data[15], imem_data[15], imem_data[15], imem_data[15],
                            imem_data[15], imem_data[15], imem_data[15], imem_data[15],
                            imem_data[15], imem_data[15], imem_data[15:0], 2'b00};
  assign known  = (op == 6'd0) || (op == 6'd2) || (op == 6'd4) || (op == 6'd5) ||
                  (op == 6'd8) || (op == 6'd35) || (op == 6'd43);

  // R1
  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (imem_addr == RESET_PC));

  // R2
  assert_seq_pc_R2: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'd8) || (op == 6'd35) || (op == 6'd43)) |=> (imem_addr == $past(nx_seq)));

  // R6
  assert_store_op_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (op == 6'd43));

  // R8
  assert_branch_R8: assert property (@(posedge clk) disable iff (rst)
    ((op == 6'd4) || (op == 6'd5)) |=>
      ((imem_addr == $past(nx_seq)) || (imem_addr == $past(nx_br))));

  // R9
  assert_jump_R9: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2) |=> (imem_addr == {$past(nx_seq[31:28]), $past(imem_data[25:0]), 2'b00}));

  // R11
  assert_undef_R11: assert property (@(posedge clk) disable iff (rst)
    !known |-> !dmem_we);

  assert_undef_pc_R11: assert property (@(posedge clk) disable iff (rst)
    !known |=> (imem_addr == $past(nx_seq)));
endmodule

bind sc32_core sc32_core_chk #(.RESET_PC(RESET_PC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_addr (imem_addr),
  .imem_data (imem_data),
  .dmem_we   (dmem_we)
);

// File: tb/sim_sc32_core.sv
module sim_sc32_core;
  localparam logic [31:0] BASE = 32'h0040_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;
  int          checks = 0;
  int          failures = 0;

  always #5 clk = ~clk;

  sc32_core u0 (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  function automatic logic [31:0] rt_enc(input int rs, input int rt, input int rd,
                                         input int sh, input int fn);
    return {6'd0, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction
  function automatic logic [31:0] it_enc(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] jt_enc(input logic [31:0] target);
    return {6'd2, target[27:2]};
  endfunction

  // power-of-two loop followed by directed cases; every result is stored
  function automatic logic [31:0] prog(input logic [31:0] a);
    logic [31:0] idx;
    idx = (a - BASE) >> 2;
    case (idx)
      0:  return it_enc(8, 0, 8, 1);
      1:  return rt_enc(0, 0, 9, 0, 32);
      2:  return it_enc(8, 0, 10, 128);
      3:  return it_enc(4, 8, 10, 3);
      4:  return rt_enc(0, 8, 8, 1, 0);
      5:  return it_enc(8, 9, 9, 1);
      6:  return jt_enc(BASE + 32'd12);
      7:  return it_enc(43, 0, 8, 0);
      8:  return it_enc(43, 0, 9, 4);
      9:  return it_enc(8, 0, 0, 5);
      10: return it_enc(43, 0, 0, 8);
      11: return it_enc(8, 0, 11, -12);
      12: return it_enc(43, 0, 11, 12);
      13: return it_enc(35, 0, 12, 12);
      14: return rt_enc(12, 9, 13, 0, 34);
      15: return it_enc(43, 0, 13, 16);
      16: return it_enc(5, 8, 10, 1);
      17: return it_enc(5, 8, 9, 1);
      18: return it_enc(8, 0, 9, 99);
      19: return it_enc(4, 8, 9, 1);
      20: return it_enc(63, 0, 9, 99);
      21: return rt_enc(8, 8, 9, 0, 63);
      22: return it_enc(43, 0, 9, 20);
      23: return it_enc(8, 0, 14, 32'h40);
      24: return rt_enc(0, 14, 14, 16, 0);
      25: return it_enc(8, 14, 14, 32'h70);
      26: return rt_enc(14, 0, 0, 0, 8);
      27: return it_enc(43, 0, 0, 24);
      28: return it_enc(43, 0, 14, 28);
      29: return jt_enc(BASE + 32'h74);
      default: return 32'd0;
    endcase
  endfunction

  assign imem_data = prog(imem_addr);

  logic [31:0] dmem [64];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (!rst && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  // behavioural reference model
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;
  string       pc_tag;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rv(input logic [4:0] i);
    return (i == 0) ? 32'd0 : mreg[i];
  endfunction

  task automatic step();
    logic [31:0] ins, a, b, sx, nxt, res;
    logic [5:0]  op, fn;
    logic        wr, st;
    logic [4:0]  wi;
    string       tag;
    ins = prog(mpc);
    op = ins[31:26]; fn = ins[5:0];
    a = rv(ins[25:21]); b = rv(ins[20:16]);
    sx = {{16{ins[15]}}, ins[15:0]};
    nxt = mpc + 4; wr = 0; st = 0; wi = ins[20:16]; res = 0; tag = "R2";
    chk({pc_tag, " pc"}, imem_addr, mpc);
    case (op)
      0: case (fn)
           32: begin wr = 1; wi = ins[15:11]; res = a + b; tag = "R3"; end
           34: begin wr = 1; wi = ins[15:11]; res = a - b; tag = "R3"; end
           0:  begin wr = 1; wi = ins[15:11]; res = b << ins[10:6]; tag = "R4"; end
           8:  begin nxt = a; tag = "R10"; end
           default: tag = "R11";
         endcase
      8:  begin wr = 1; res = a + sx; tag = "R5"; end
      35: begin wr = 1; res = mmem[(a + sx) >> 2]; tag = "R6"; end
      43: begin st = 1; tag = "R6"; end
      4:  begin if (a == b) nxt = mpc + 4 + (sx << 2); tag = "R8"; end
      5:  begin if (a != b) nxt = mpc + 4 + (sx << 2); tag = "R8"; end
      2:  begin nxt = {mpc[31:28] + 4'd0, ins[25:0], 2'b00}; tag = "R9"; end
      default: tag = "R11";
    endcase
    chk({tag, " store strobe"}, {31'd0, dmem_we}, {31'd0, st});
    if (st) begin
      chk("R6 store address", dmem_addr, a + sx);
      chk("R6 store data", dmem_wdata, b);
      mmem[(a + sx) >> 2] = b;
    end
    if (wr && wi != 0) mreg[wi] = res;
    mpc = nxt;
    pc_tag = tag;
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin dmem[i] = 32'hDEAD_BEEF; mmem[i] = 32'hDEAD_BEEF; end
    for (int i = 0; i < 32; i++) mreg[i] = 32'd0;
    pc_tag = "R1";
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset pc", imem_addr, BASE);
    chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
    rst = 1'b0;
    mpc = BASE;
    for (int c = 0; c < 90; c++) begin
      step();
      @(negedge clk);
    end
    chk("R12 loop value", dmem[0], 32'd128);
    chk("R12 loop count", dmem[1], 32'd7);
    chk("R7 zero register", dmem[2], 32'd0);
    chk("R5 negative immediate", dmem[3], 32'hFFFF_FFF4);
    chk("R3 sub after load", dmem[4], 32'hFFFF_FFED);
    chk("R11 undefined left reg intact", dmem[5], 32'd7);
    chk("R10 skipped store", dmem[6], 32'hDEAD_BEEF);
    chk("R4 sll built address", dmem[7], 32'h0040_0070);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1 reset mid-run", imem_addr, BASE);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule